// File: doc/BRIEF.md
# Control Pipe Response and Toggle Register

This block is the 16-bit control and status word for the default control pipe of a USB host/function controller. It is combined with a small unit that selects the handshake. Software reaches it through a single-word register port. A write updates the writable fields and fires the write-1 strobes. A read returns the stored state together with two flags that the link layer maintains. The link side reports four events: a transaction in progress, a data transaction that succeeded, a setup packet that has left the wire, and whether the buffer may be accessed.

The block has three outputs. The first is the handshake that the serializer should give: NAK, a reply that depends on the buffer, or STALL. The second is the current data toggle. The third is a request to send a setup packet. Software can move the toggle to DATA0 or DATA1, but only while the pipe is answering NAK. A strobe that arrives while the pipe answers anything else is dropped. This way a toggle change cannot race a transaction that is already running.

The reset is synchronous and active high. All state is held in flops, and every output is driven from those flops.

Top module: `ctlpipe_resp_reg`

## Requirements
- R1: After reset the read value is 0x0040: the toggle is DATA1 (`toggle_out`=1), `resp_code` is 00, and `setup_req` and `xfer_end_en` are 0.
- R2: Bits [1:0] hold the stored response field, and `resp_code` decodes it as follows: 00 gives NAK (00), 01 gives the buffer-dependent reply (01), and both 10 and 11 give STALL (10). A read returns the field as it was written.
- R3: Bit 2 is read/write and drives `xfer_end_en`.
- R4: Bit 5 reads back `lnk_busy` as it was sampled at the previous clock edge. Writes to bit 5 have no effect.
- R5: Bit 15 reads back `lnk_buf_ok` as it was sampled at the previous clock edge. Writes to bit 15 have no effect.
- R6: Bit 6 shows the toggle (0 = DATA0, 1 = DATA1). Each `lnk_ack` pulse flips it, unless an accepted strobe write arrives in the same cycle.
- R7: While the stored response field is 00, writing 1 to bit 7 sets the toggle to DATA1 and writing 1 to bit 8 sets it to DATA0. If both bits are 1, DATA1 wins. An accepted strobe overrides a simultaneous `lnk_ack`.
- R8: A toggle strobe is ignored when the response field held before the write is not 00. This includes a write that moves the field to 00 in the same cycle. In that case a simultaneous `lnk_ack` still flips the toggle.
- R9: Writing 1 to bit 14 raises `setup_req`, and bit 14 reads back that request. Writing 0 to bit 14 does not change it.
- R10: Writing 1 to bit 11 clears `setup_req`. If bit 11 and bit 14 are both 1 in the same write, the clear wins.
- R11: `lnk_setup_sent` clears `setup_req`, unless a write in the same cycle sets it.
- R12: The strobe bits 7, 8 and 11 always read 0. The reserved bits 3, 4, 9, 10, 12 and 13 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| lnk_busy | input | 1 | Link: pipe is in a transaction |
| lnk_ack | input | 1 | Link: data transaction succeeded, flip toggle |
| lnk_setup_sent | input | 1 | Link: setup packet transmitted |
| lnk_buf_ok | input | 1 | Link: buffer access allowed |
| resp_code | output | 2 | Handshake to give: 00 NAK, 01 buffer-dependent, 10 STALL |
| toggle_out | output | 1 | Current data toggle |
| setup_req | output | 1 | Request to transmit a setup packet |
| xfer_end_en | output | 1 | Control transfer completion enabled |

## Verification
The hardest cases to reach are the collisions on the toggle. One is a strobe write landing in the same cycle as `lnk_ack`. The other is a strobe carried by the very write that moves the response field to or from NAK. The outcome of each depends on which value of the field gates the write. The bench drives these collisions on purpose: it sets a non-NAK field, then writes a NAK field together with a strobe and a link acknowledge in the same cycle. It then repeats the case in the opposite direction. A long seeded random phase follows, which mixes writes and link events, and a behavioural model is compared against every output on every clock.

// File: rtl/ctlpipe_pkg.sv
package ctlpipe_pkg;
  localparam int REG_W = 16;
  localparam int RC_W  = 2;

  typedef enum logic [RC_W-1:0] {
    RESP_NAK   = 2'b00,
    RESP_BUF   = 2'b01,
    RESP_STALL = 2'b10
  } resp_e;

  localparam int B_RC0    = 0;
  localparam int B_RC1    = 1;
  localparam int B_END    = 2;
  localparam int B_BUSY   = 5;
  localparam int B_TOG    = 6;
  localparam int B_TSET   = 7;
  localparam int B_TCLR   = 8;
  localparam int B_SCLR   = 11;
  localparam int B_SREQ   = 14;
  localparam int B_BUFOK  = 15;

  localparam logic [REG_W-1:0] RST_VAL   = 16'h0040;
  localparam logic [REG_W-1:0] RSVD_MASK = 16'h3618;
  localparam logic [REG_W-1:0] STRB_MASK = 16'h0980;
endpackage

// File: rtl/ctlpipe_resp_sel.sv
module ctlpipe_resp_sel
  import ctlpipe_pkg::*;
#(
  parameter int W = RC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  input  logic         wr_end,
  output logic [W-1:0] code_q,
  output logic         is_nak,
  output logic [W-1:0] resp_code,
  output logic         end_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      end_en <= 1'b0;
    end else if (wr_en) begin
      code_q <= wr_code;
      end_en <= wr_end;
    end
  end

  assign is_nak = (code_q == '0);

  always_comb begin
    if (code_q[W-1])        resp_code = RESP_STALL;
    else if (code_q[0])     resp_code = RESP_BUF;
    else                    resp_code = RESP_NAK;
  end
endmodule

// File: rtl/ctlpipe_toggle.sv
module ctlpipe_toggle #(
  parameter logic RESET_TOG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_open,
  input  logic wr_en,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic ack,
  output logic tog_q
);
  logic take;
  assign take = wr_en && gate_open && (set_stb || clr_stb);

  always_ff @(posedge clk) begin
    if (rst)       tog_q <= RESET_TOG;
    else if (take) tog_q <= set_stb;
    else if (ack)  tog_q <= ~tog_q;
  end
endmodule

// File: rtl/ctlpipe_setup_req.sv
module ctlpipe_setup_req (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic sent,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst)                      req_q <= 1'b0;
    else if (wr_en && clr_stb)    req_q <= 1'b0;
    else if (wr_en && set_stb)    req_q <= 1'b1;
    else if (sent)                req_q <= 1'b0;
  end
endmodule

// File: rtl/ctlpipe_resp_reg.sv
module ctlpipe_resp_reg
  import ctlpipe_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          lnk_busy,
  input  logic          lnk_ack,
  input  logic          lnk_setup_sent,
  input  logic          lnk_buf_ok,
  output logic [1:0]    resp_code,
  output logic          toggle_out,
  output logic          setup_req,
  output logic          xfer_end_en
);
  logic [RC_W-1:0] code_q;
  logic            is_nak;
  logic            busy_q;
  logic            bufok_q;

  ctlpipe_resp_sel #(.W(RC_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_code  (wr_data[B_RC1:B_RC0]),
    .wr_end   (wr_data[B_END]),
    .code_q   (code_q),
    .is_nak   (is_nak),
    .resp_code(resp_code),
    .end_en   (xfer_end_en)
  );

  ctlpipe_toggle #(.RESET_TOG(RST_VAL[B_TOG])) u_tog (
    .clk      (clk),
    .rst      (rst),
    .gate_open(is_nak),
    .wr_en    (wr_en),
    .set_stb  (wr_data[B_TSET]),
    .clr_stb  (wr_data[B_TCLR]),
    .ack      (lnk_ack),
    .tog_q    (toggle_out)
  );

  ctlpipe_setup_req u_sreq (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .set_stb(wr_data[B_SREQ]),
    .clr_stb(wr_data[B_SCLR]),
    .sent   (lnk_setup_sent),
    .req_q  (setup_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      bufok_q <= 1'b0;
    end else begin
      busy_q  <= lnk_busy;
      bufok_q <= lnk_buf_ok;
    end
  end

  logic [DW-1:0] fields;
  always_comb begin
    fields          = '0;
    fields[B_RC1:B_RC0] = code_q;
    fields[B_END]   = xfer_end_en;
    fields[B_BUSY]  = busy_q;
    fields[B_TOG]   = toggle_out;
    fields[B_SREQ]  = setup_req;
    fields[B_BUFOK] = bufok_q;
  end

  for (genvar i = 0; i < DW; i++) begin : g_rd
    if (RSVD_MASK[i] || STRB_MASK[i]) begin : g_zero
      assign rd_data[i] = 1'b0;
    end else begin : g_live
      assign rd_data[i] = fields[i];
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wr_data[4:3], wr_data[6:5], wr_data[10:9],
                          wr_data[13:12], wr_data[15], fields & (RSVD_MASK | STRB_MASK)};
endmodule

// File: rtl/ctlpipe_resp_reg_chk.sv
module ctlpipe_resp_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        lnk_busy,
  input logic        lnk_ack,
  input logic        lnk_setup_sent,
  input logic        lnk_buf_ok,
  input logic [1:0]  resp_code,
  input logic        toggle_out,
  input logic        setup_req
);
  logic rst_q = 1'b0;
  always @(posedge clk) begin
    if (rst_q && !rst)
      assert_reset_val_R1: assert (rd_data == 16'h0040 && resp_code == 2'b00 && !setup_req);
    rst_q <= rst;
  end

  assert_stall_fold_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |-> resp_code == 2'b10);

  assert_busy_follow_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_data[5] == $past(lnk_busy));

  assert_bufok_follow_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_data[15] == $past(lnk_buf_ok));

  assert_ack_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (lnk_ack && !wr_en) |=> toggle_out != $past(toggle_out));

  assert_strobe_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_data[1:0] != 2'b00 && !lnk_ack) |=> $stable(toggle_out));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[11]) |=> !setup_req);

  assert_sent_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (lnk_setup_sent && !wr_en) |=> !setup_req);

  assert_zero_bits_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 16'h3F98) == 16'h0000);
endmodule

bind ctlpipe_resp_reg ctlpipe_resp_reg_chk u_chk (.*);

// File: tb/ctlpipe_resp_reg_tb.sv
module ctlpipe_resp_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        lnk_busy = 1'b0, lnk_ack = 1'b0, lnk_setup_sent = 1'b0, lnk_buf_ok = 1'b0;
  logic [1:0]  resp_code;
  logic        toggle_out, setup_req, xfer_end_en;

  always #10 clk = ~clk;

  ctlpipe_resp_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lnk_busy(lnk_busy), .lnk_ack(lnk_ack), .lnk_setup_sent(lnk_setup_sent),
    .lnk_buf_ok(lnk_buf_ok), .resp_code(resp_code), .toggle_out(toggle_out),
    .setup_req(setup_req), .xfer_end_en(xfer_end_en)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int m_code, m_end, m_busy, m_buf, m_tog, m_sreq;

  task automatic chk(string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, sig, act, exp);
    end
  endtask

  function automatic int exp_rd();
    return m_code | (m_end << 2) | (m_busy << 5) | (m_tog << 6) | (m_sreq << 14) | (m_buf << 15);
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_code = 0; m_end = 0; m_busy = 0; m_buf = 0; m_tog = 1; m_sreq = 0;
    end else begin
      if (wr_en && m_code == 0 && (wr_data[7] || wr_data[8])) m_tog = wr_data[7] ? 1 : 0;
      else if (lnk_ack) m_tog = 1 - m_tog;
      if (wr_en && wr_data[11]) m_sreq = 0;
      else if (wr_en && wr_data[14]) m_sreq = 1;
      else if (lnk_setup_sent) m_sreq = 0;
      if (wr_en) begin m_code = wr_data[1:0]; m_end = wr_data[2]; end
      m_busy = lnk_busy; m_buf = lnk_buf_ok;
    end
  endtask

  task automatic compare_all();
    chk("rd_data", rd_data, exp_rd());
    chk("resp_code", resp_code, (m_code >= 2) ? 2 : m_code);
    chk("toggle_out", toggle_out, m_tog);
    chk("setup_req", setup_req, m_sreq);
    chk("xfer_end_en", xfer_end_en, m_end);
  endtask

  task automatic step(input logic w, input logic [15:0] d, input logic ack,
                      input logic sent, input logic busy, input logic bok);
    wr_en = w; wr_data = d; lnk_ack = ack; lnk_setup_sent = sent;
    lnk_busy = busy; lnk_buf_ok = bok;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [15:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic ack, input logic sent);
    step(1'b0, 16'h0, ack, sent, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    tag = "R1";
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    idle(1'b0, 1'b0);
    chk("reset_value", rd_data, 16'h0040);

    tag = "R2";
    for (int c = 0; c < 4; c++) begin
      wr(16'(c));
      chk("resp_code_enc", resp_code, (c >= 2) ? 2 : c);
    end
    wr(16'h0000);

    tag = "R3";
    wr(16'h0004); wr(16'h0000);

    tag = "R4";
    step(1'b1, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0);
    tag = "R5";
    step(1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);

    tag = "R6";
    idle(1'b1, 1'b0); idle(1'b1, 1'b0); idle(1'b1, 1'b0); idle(1'b0, 1'b0);

    tag = "R7";
    wr(16'h0100); wr(16'h0080); wr(16'h0100);
    wr(16'h0180);
    chk("both_strobes_data1", toggle_out, 1);
    step(1'b1, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0);

    tag = "R8";
    wr(16'h0001); wr(16'h0181); wr(16'h0101);
    step(1'b1, 16'h0081, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(16'h0002); wr(16'h0102);
    wr(16'h0003); wr(16'h0083);
    step(1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 16'h0081, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(16'h0000);

    tag = "R9";
    wr(16'h4000); wr(16'h0000);
    chk("sreq_write0_keeps", setup_req, 1);
    tag = "R10";
    wr(16'h0800);
    wr(16'h4800);
    tag = "R11";
    wr(16'h4000);
    idle(1'b0, 1'b1);
    wr(16'h4000);
    step(1'b1, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b0);

    tag = "R12";
    wr(16'hFFFF);
    chk("zero_bits", rd_data & 16'h3F98, 0);
    wr(16'h3F98);
    wr(16'h0000);

    tag = "R8";
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      d[1] = d[1] & d[3];
      step(1'($urandom_range(0, 1)), d, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule